// File: doc/BRIEF.md
# Home-Core Migration Decision Unit

This unit sits between a core's load/store stage and its local cache in a multicore where every physical address may be cached by exactly one core. For each memory access it computes the owning ("home") core from the address. The address space is striped across the cores in fixed-size blocks. Block index k belongs to core k modulo the core count, so the assignment wraps back to core 0 after the last core.

When the home core is the local core, the access goes to the local cache one cycle after it is accepted. When the home core is elsewhere, the unit raises a precise migration trap instead, and the access never reaches the local cache. The trap freezes the pipeline, stops accepting further accesses and asks the context transfer logic to ship the thread. The request carries the destination core, the faulting address and the program counter of the faulting instruction, and it is held until it is acknowledged. On the destination core the same access is issued again and completes there as a local access.

Top module: `home_migrate_unit`

## Requirements
- R1: While reset is low and in the first cycle after it, `cache_valid`, `mig_req` and `pipe_freeze` are low and `req_ready` is high.
- R2: The home core is address bits [S+CW-1:S], where CW = log2(NUM_CORES) and S depends on `stripe_sel`: 0 gives S=6 (64-byte blocks), 1 gives S=12 (4096 bytes), and 2 or 3 give S=14 (16384 bytes).
- R3: An accepted access whose home equals `core_id` raises `cache_valid` for exactly one cycle, in the cycle after acceptance. In that cycle it carries the access's address, write flag and write data, and `mig_req` stays low.
- R4: An accepted access whose home differs from `core_id` raises `mig_req` in the cycle after acceptance. `mig_dest` carries the home core, and `mig_pc` and `mig_addr` carry the faulting access; `cache_valid` stays low for that access.
- R5: While `mig_req` is high and `mig_ack` is low, `mig_req`, `mig_dest`, `mig_pc` and `mig_addr` hold their values. In the cycle after a cycle with both high, `mig_req` is low.
- R6: While a migration is pending, `pipe_freeze` is high and `req_ready` is low. Any `req_valid` in that time is ignored: it produces no cache access and does not change the pending request.
- R7: In the cycle after the acknowledge, `pipe_freeze` is low and `req_ready` is high. The faulting access, issued again with `core_id` set to the former destination, completes as a local access per R3.
- R8: Block indices at or above NUM_CORES wrap, so block index NUM_CORES + j maps to core j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_id | input | CW | Identity of the local core |
| stripe_sel | input | 2 | Static stripe size selection |
| req_valid | input | 1 | Access presented by the pipeline |
| req_ready | output | 1 | Unit accepts an access this cycle |
| req_addr | input | ADDR_W | Physical address of the access |
| req_we | input | 1 | Access is a store |
| req_wdata | input | DATA_W | Store data |
| req_pc | input | PC_W | Program counter of the access |
| cache_valid | output | 1 | Local cache request strobe |
| cache_addr | output | ADDR_W | Local cache request address |
| cache_we | output | 1 | Local cache request is a store |
| cache_wdata | output | DATA_W | Local cache store data |
| mig_req | output | 1 | Migration trap request |
| mig_ack | input | 1 | Context transfer accepted |
| mig_dest | output | CW | Destination core of the migration |
| mig_pc | output | PC_W | PC of the faulting instruction |
| mig_addr | output | ADDR_W | Address of the faulting access |
| pipe_freeze | output | 1 | Stop commit of younger instructions |

## Verification
The bench sweeps every local core, every stripe setting and block indices past the core count on a four-core build. A wrong offset, a missing wrap or a truncated home field would send accesses to the wrong core, show up as a spurious migration, or let a remote access through to the local cache. Each migration is held unacknowledged for several cycles while an access to a local address is offered. A unit that dropped the request early, let operands drift or accepted the new access would show a lost trap or a cache access the pipeline never intended. After each acknowledge, the faulting access is issued again as the destination core. This catches a unit that stays frozen or computes the home from stale state.

// File: rtl/home_migrate_unit.sv
module home_migrate_unit #(
  parameter int NUM_CORES = 64,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int PC_W      = 32,
  parameter int OFF_SMALL = 6,
  parameter int OFF_MID   = 12,
  parameter int OFF_LARGE = 14,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     core_id,
  input  logic [1:0]        stripe_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [PC_W-1:0]   req_pc,
  output logic              cache_valid,
  output logic [ADDR_W-1:0] cache_addr,
  output logic              cache_we,
  output logic [DATA_W-1:0] cache_wdata,
  output logic              mig_req,
  input  logic              mig_ack,
  output logic [CW-1:0]     mig_dest,
  output logic [PC_W-1:0]   mig_pc,
  output logic [ADDR_W-1:0] mig_addr,
  output logic              pipe_freeze
);

  logic [ADDR_W-1:0] shifted;
  logic [CW-1:0]     home;
  logic              accept, local_hit;

  logic              hit_q, mig_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [PC_W-1:0]   pc_q;
  logic [CW-1:0]     dest_q;

  always_comb begin
    case (stripe_sel)
      2'd0:    shifted = req_addr >> OFF_SMALL;
      2'd1:    shifted = req_addr >> OFF_MID;
      default: shifted = req_addr >> OFF_LARGE;
    endcase
  end

  assign home      = shifted[CW-1:0];
  assign accept    = req_valid && !mig_q;
  assign local_hit = (home == core_id);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      mig_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      pc_q    <= '0;
      dest_q  <= '0;
    end else begin
      hit_q <= accept && local_hit;
      if (accept) begin
        addr_q  <= req_addr;
        we_q    <= req_we;
        wdata_q <= req_wdata;
        pc_q    <= req_pc;
        dest_q  <= home;
        mig_q   <= !local_hit;
      end else if (mig_q && mig_ack) begin
        mig_q <= 1'b0;
      end
    end
  end

  assign req_ready   = !mig_q;
  assign pipe_freeze = mig_q;
  assign cache_valid = hit_q;
  assign cache_addr  = addr_q;
  assign cache_we    = we_q;
  assign cache_wdata = wdata_q;
  assign mig_req     = mig_q;
  assign mig_dest    = dest_q;
  assign mig_pc      = pc_q;
  assign mig_addr    = addr_q;

endmodule

module home_migrate_unit_chk #(
  parameter int ADDR_W    = 32,
  parameter int PC_W      = 32,
  parameter int CW        = 6,
  parameter int OFF_SMALL = 6,
  parameter int OFF_MID   = 12,
  parameter int OFF_LARGE = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CW-1:0]     core_id,
  input logic [1:0]        stripe_sel,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cache_valid,
  input logic [ADDR_W-1:0] cache_addr,
  input logic              mig_req,
  input logic              mig_ack,
  input logic [CW-1:0]     mig_dest,
  input logic [PC_W-1:0]   mig_pc,
  input logic              pipe_freeze
);

  logic [ADDR_W-1:0] c_sh;
  always_comb begin
    case (stripe_sel)
      2'd0:    c_sh = cache_addr >> OFF_SMALL;
      2'd1:    c_sh = cache_addr >> OFF_MID;
      default: c_sh = cache_addr >> OFF_LARGE;
    endcase
  end

  a_r3_hit_is_local: assert property (@(posedge clk) disable iff (!rst_n)
    cache_valid |-> c_sh[CW-1:0] == core_id);

  a_r3_one_cycle_decision: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cache_valid || mig_req));

  a_r4_no_cache_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    !(cache_valid && mig_req));

  a_r4_dest_remote: assert property (@(posedge clk) disable iff (!rst_n)
    mig_req |-> mig_dest != core_id);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mig_req && !mig_ack) |=> (mig_req && $stable(mig_dest) && $stable(mig_pc)));

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mig_req && mig_ack) |=> !mig_req);

  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    mig_req |-> (pipe_freeze && !req_ready));

endmodule

bind home_migrate_unit home_migrate_unit_chk #(
  .ADDR_W(ADDR_W), .PC_W(PC_W), .CW(CW),
  .OFF_SMALL(OFF_SMALL), .OFF_MID(OFF_MID), .OFF_LARGE(OFF_LARGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .core_id(core_id), .stripe_sel(stripe_sel),
  .req_valid(req_valid), .req_ready(req_ready), .cache_valid(cache_valid),
  .cache_addr(cache_addr), .mig_req(mig_req), .mig_ack(mig_ack),
  .mig_dest(mig_dest), .mig_pc(mig_pc), .pipe_freeze(pipe_freeze)
);

// File: tb/test_home_migrate_unit.sv
module test_home_migrate_unit;
  localparam int NC = 4;
  localparam int AW = 20;
  localparam int DW = 32;
  localparam int PW = 32;
  localparam int CW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_we, mig_ack;
  logic [CW-1:0] core_id;
  logic [1:0] stripe_sel;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [PW-1:0] req_pc;
  logic req_ready, cache_valid, cache_we, mig_req, pipe_freeze;
  logic [AW-1:0] cache_addr, mig_addr;
  logic [DW-1:0] cache_wdata;
  logic [CW-1:0] mig_dest;
  logic [PW-1:0] mig_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  home_migrate_unit #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW), .PC_W(PW)) i_home_migrate_unit (
    .clk(clk), .rst_n(rst_n), .core_id(core_id), .stripe_sel(stripe_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata), .req_pc(req_pc),
    .cache_valid(cache_valid), .cache_addr(cache_addr), .cache_we(cache_we),
    .cache_wdata(cache_wdata), .mig_req(mig_req), .mig_ack(mig_ack),
    .mig_dest(mig_dest), .mig_pc(mig_pc), .mig_addr(mig_addr),
    .pipe_freeze(pipe_freeze)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int off_of(input int sel);
    return (sel == 0) ? 6 : (sel == 1) ? 12 : 14;
  endfunction

  task automatic expect_hit(input logic [AW-1:0] a, input logic [PW-1:0] pc,
                            input logic we, input logic [DW-1:0] wd, input string tag);
    @(negedge clk);
    check(req_ready == 1'b1, "R7 ready before access", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_pc = pc; req_we = we; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(cache_valid == 1'b1, {tag, " R3 cache_valid"}, cache_valid, 1);
    check(cache_addr == a, "R3 cache_addr", cache_addr, a);
    check(cache_we == we && cache_wdata == wd, "R3 cache we/data", cache_wdata, wd);
    check(mig_req == 1'b0, "R3 no mig", mig_req, 0);
    @(negedge clk);
    check(cache_valid == 1'b0, "R3 single cycle", cache_valid, 0);
  endtask

  task automatic access(input logic [AW-1:0] a, input logic [PW-1:0] pc,
                        input logic we, input logic [DW-1:0] wd,
                        input logic [CW-1:0] exp_home, input string tag, input int hold);
    logic [CW-1:0] saved;
    if (exp_home == core_id) begin
      expect_hit(a, pc, we, wd, tag);
    end else begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_pc = pc; req_we = we; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      check(mig_req == 1'b1, {tag, " R4 mig_req"}, mig_req, 1);
      check(mig_dest == exp_home, {tag, " R4 mig_dest"}, mig_dest, exp_home);
      check(mig_pc == pc && mig_addr == a, "R4 mig pc/addr", mig_addr, a);
      check(cache_valid == 1'b0, "R4 no local cache", cache_valid, 0);
      check(pipe_freeze == 1'b1 && req_ready == 1'b0, "R6 freeze", pipe_freeze, 1);
      for (int i = 0; i < hold; i++) begin
        if (i == 0) begin
          req_valid = 1'b1;
          req_addr = AW'(core_id) << off_of(int'(stripe_sel));
          req_pc = ~pc;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(mig_req == 1'b1 && mig_dest == exp_home, "R5 hold req/dest", mig_dest, exp_home);
        check(mig_pc == pc && mig_addr == a, "R5 hold pc/addr", mig_pc, pc);
        check(cache_valid == 1'b0, "R6 ignored access", cache_valid, 0);
      end
      mig_ack = 1'b1;
      @(negedge clk);
      mig_ack = 1'b0;
      check(mig_req == 1'b0, "R5 release", mig_req, 0);
      check(pipe_freeze == 1'b0 && req_ready == 1'b1, "R7 resume", req_ready, 1);
      check(cache_valid == 1'b0, "R6 no late cache", cache_valid, 0);
      saved = core_id;
      core_id = exp_home;
      expect_hit(a, pc, we, wd, "R7 retry");
      core_id = saved;
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; mig_ack = 1'b0;
    core_id = '0; stripe_sel = '0; req_addr = '0; req_wdata = '0; req_pc = '0;
    repeat (3) @(negedge clk);
    check(!cache_valid && !mig_req && !pipe_freeze && req_ready, "R1 in reset", mig_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cache_valid && !mig_req && !pipe_freeze && req_ready, "R1 after reset", mig_req, 0);

    for (int cid = 0; cid < NC; cid++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int blk = 0; blk < 2 * NC; blk++) begin
          logic [AW-1:0] a;
          logic [PW-1:0] pc;
          core_id = CW'(cid);
          stripe_sel = 2'(sel);
          a = (AW'(blk) << off_of(sel)) | AW'(cid * 4 + 3);
          pc = PW'(32'h1000 + cid * 256 + sel * 16 + blk);
          access(a, pc, blk[0], pc ^ 32'h5a5a_a5a5, CW'(blk % NC),
                 (blk >= NC) ? "R8 wrap" : "R2 home", (blk % 3) + 1);
        end
      end
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule